// File: doc/BRIEF.md
# Dual-Mode Baud Tick Generator

This block makes the single-cycle enable pulse, at sixteen times the serial bit rate, that paces a UART transmitter and receiver. Software loads a 16-bit rate word and a control word through a small write port. The generator then makes pulses in one of two ways. The first is a plain integer divider that fires once every N clocks. The second is a 16-bit phase accumulator that adds the rate word on every clock and fires on each carry out of bit 15.

The divider suits low bit rates, where the rate word is clk/(16*baud) and rounding costs little. The accumulator suits high bit rates, where the rate word is baud*16*2^16/clk and the mean pulse rate is exact to 1/65536 of the clock. A run bit in the control word gates the generator. Changing the rate word or the mode starts the selected engine again from a clean phase, so the new rate takes effect at once.

Top module: `baudgen_top`

## Requirements
- R1: After reset the rate word is 0, the run bit is 0, the mode is the divider, and `tick_o` is low.
- R2: In divider mode (control bit 12 = 0) with run set and rate word N ≥ 1, `tick_o` pulses high for one cycle every N clocks exactly, so N = 1 gives a pulse on every clock.
- R3: In divider mode a rate word of 0 yields no pulse at all.
- R4: In accumulator mode (control bit 12 = 1) with run set and rate word R, exactly R pulses appear in the 65536 clocks that follow a restart (checked within ±1).
- R5: In accumulator mode with a rate word of 2^k, the pulses are exactly 2^(16-k) clocks apart.
- R6: A write with `wr_sel` = 1 loads the control word. Bit 7 is run and bit 12 selects the mode. A write with `wr_sel` = 0 loads the rate word.
- R7: While run is 0, `tick_o` stays low from the clock edge that takes the write onward. When run is set again, the first pulse comes a full period later.
- R8: A write to the rate word restarts the engine. In divider mode the first pulse after a write taken at edge E is seen after edge E+N.
- R9: A control write that changes the mode restarts both engines. The first pulse in the new mode comes one full period of that mode after the write.
- R10: The mean pulse count in divider mode over a window of W clocks is floor(W/N) within ±1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = rate word, 1 = control word |
| wr_data | input | 16 | Write data |
| tick_o | output | 1 | 16x oversampling enable pulse |

## Verification
In divider mode the rates tried are 1, 5 and 10, plus 0. These show that the pulse spacing is exact, that a pulse can fire on every clock, that the long-run mean is right, and that a zero rate word stays silent. In accumulator mode a power-of-two word shows the exact spacing. An odd word over a full 2^16-clock window shows that the mean is exact where the spacing is not. Three further cases rewrite the rate word in the middle of a count, switch modes in both directions, and clear run and set it again. Each of these checks the cycle of the first pulse afterwards, which shows whether the phase was cleared or carried over.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

    localparam int RATE_W        = 16;
    localparam int CTRL_RUN_BIT  = 7;
    localparam int CTRL_MODE_BIT = 12;

    typedef enum logic {
        GEN_DIVIDE = 1'b0,
        GEN_PHASE  = 1'b1
    } gen_mode_e;

    typedef enum logic {
        SEL_RATE = 1'b0,
        SEL_CTRL = 1'b1
    } wr_sel_e;

    typedef struct packed {
        logic              run;
        gen_mode_e         mode;
        logic [RATE_W-1:0] rate;
    } gen_cfg_t;

    function automatic gen_mode_e ctrl_mode(input logic [15:0] word);
        return gen_mode_e'(word[CTRL_MODE_BIT]);
    endfunction

    function automatic logic ctrl_run(input logic [15:0] word);
        return word[CTRL_RUN_BIT];
    endfunction

endpackage

// File: rtl/baudgen_regs.sv
module baudgen_regs
    import baudgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wr_sel_e           wr_sel,
    input  logic [15:0]       wr_data,
    output gen_cfg_t          cfg_o,
    output logic              restart_o
);

    gen_cfg_t cfg_q;

    // Restart is taken in the same edge that loads the new value.
    always_comb begin
        restart_o = 1'b0;
        if (wr_en) begin
            if (wr_sel == SEL_RATE)
                restart_o = 1'b1;
            else if (ctrl_mode(wr_data) != cfg_q.mode)
                restart_o = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.run  <= 1'b0;
            cfg_q.mode <= GEN_DIVIDE;
            cfg_q.rate <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_RATE) begin
                cfg_q.rate <= wr_data[RATE_W-1:0];
            end else begin
                cfg_q.run  <= ctrl_run(wr_data);
                cfg_q.mode <= ctrl_mode(wr_data);
            end
        end
    end

    assign cfg_o = cfg_q;

    // R1: configuration is cleared by reset
    a_r1_reset_cfg: assert property (@(posedge clk)
        rst |=> (!cfg_q.run && cfg_q.rate == '0 && cfg_q.mode == GEN_DIVIDE));

endmodule

// File: rtl/baudgen_div.sv
module baudgen_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         clear,
    input  logic [W-1:0] rate,
    output logic         tick_o
);

    logic [W-1:0] cnt_q;
    logic         tick_q;
    logic [W-1:0] last;

    assign last = rate - W'(1);

    always_ff @(posedge clk) begin
        if (rst || clear || !en || rate == '0) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q == last) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + W'(1);
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    a_r3_zero_rate_silent: assert property (@(posedge clk) disable iff (rst)
        (en && rate == '0) |=> !tick_q);

    a_r2_count_below_rate: assert property (@(posedge clk) disable iff (rst)
        (en && rate != '0) |-> (cnt_q < rate));

    a_r7_div_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0 && !tick_q));

    a_r8_div_restart: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0 && !tick_q));

endmodule

// File: rtl/baudgen_acc.sv
module baudgen_acc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         clear,
    input  logic [W-1:0] rate,
    output logic         tick_o
);

    logic [W-1:0] acc_q;
    logic         tick_q;
    logic [W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, rate};

    always_ff @(posedge clk) begin
        if (rst || clear || !en) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= sum[W-1:0];
            tick_q <= sum[W];
        end
    end

    assign tick_o = tick_q;

    a_r9_acc_restart: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc_q == '0 && !tick_q));

    a_r7_acc_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> (acc_q == '0 && !tick_q));

    // R4: a carry can only follow an enabled cycle with a nonzero rate
    a_r4_carry_needs_rate: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> ($past(en) && $past(rate) != '0));

endmodule

// File: rtl/baudgen_top.sv
module baudgen_top
    import baudgen_pkg::*;
#(
    parameter int W = RATE_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [15:0] wr_data,
    output logic        tick_o
);

    gen_cfg_t cfg;
    logic     restart;
    logic     div_tick;
    logic     acc_tick;
    logic     div_en;
    logic     acc_en;

    baudgen_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel_e'(wr_sel)),
        .wr_data   (wr_data),
        .cfg_o     (cfg),
        .restart_o (restart)
    );

    assign div_en = cfg.run && (cfg.mode == GEN_DIVIDE);
    assign acc_en = cfg.run && (cfg.mode == GEN_PHASE);

    baudgen_div #(.W(W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .en     (div_en),
        .clear  (restart),
        .rate   (cfg.rate[W-1:0]),
        .tick_o (div_tick)
    );

    baudgen_acc #(.W(W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .en     (acc_en),
        .clear  (restart),
        .rate   (cfg.rate[W-1:0]),
        .tick_o (acc_tick)
    );

    always_comb begin
        if (!cfg.run)
            tick_o = 1'b0;
        else if (cfg.mode == GEN_PHASE)
            tick_o = acc_tick;
        else
            tick_o = div_tick;
    end

    a_r6_engine_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({div_tick, acc_tick}));

endmodule

// File: tb/tb_baudgen_top.sv
module tb_baudgen_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic        wr_sel;
    logic [15:0] wr_data;
    logic        tick_o;

    int tests_run  = 0;
    int tests_fail = 0;
    int cycles     = 0;

    localparam logic [15:0] CTL_RUN_DIV = 16'h0080;
    localparam logic [15:0] CTL_RUN_ACC = 16'h1080;
    localparam logic [15:0] CTL_STOP    = 16'h0000;

    always #2.5 clk = ~clk;

    baudgen_top dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .tick_o  (tick_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            tests_fail = tests_fail + 1;
            $display("FAIL watchdog: run did not end, actual %0d cycles expected < 190000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests_run = tests_run + 1;
        if (!ok) begin
            tests_fail = tests_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at a negedge; returns at the next negedge, after the write edge E.
    task automatic wr(input logic sel, input logic [15:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Looks at cycles 1..n after E; returns the index of the first pulse, 0 if none.
    task automatic first_tick(input int n, output int idx);
        idx = 0;
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            if (tick_o && idx == 0) idx = j;
        end
    endtask

    task automatic count_ticks(input int n, output int cnt);
        cnt = 0;
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            if (tick_o) cnt++;
        end
    endtask

    task automatic test_reset();
        int c;
        check(tick_o == 1'b0, "R1 tick low after reset", int'(tick_o), 0);
        count_ticks(20, c);
        check(c == 0, "R1 no pulses while idle", c, 0);
    endtask

    task automatic test_div_period();
        int idx;
        int gaps_ok;
        int prev;
        wr(1'b1, CTL_RUN_DIV);
        wr(1'b0, 16'd5);
        first_tick(5, idx);
        check(idx == 5, "R8 first pulse N cycles after rate write", idx, 5);
        gaps_ok = 1;
        prev = 0;
        for (int j = 1; j <= 30; j++) begin
            @(negedge clk);
            if (tick_o) begin
                if (j - prev != 5) gaps_ok = 0;
                prev = j;
            end
        end
        check(gaps_ok == 1 && prev == 30, "R2 pulse spacing N=5", prev, 30);
    endtask

    task automatic test_div_one();
        int c;
        wr(1'b0, 16'd1);
        count_ticks(16, c);
        check(c == 16, "R2 N=1 pulses every clock", c, 16);
    endtask

    task automatic test_div_zero();
        int c;
        wr(1'b0, 16'd0);
        count_ticks(200, c);
        check(c == 0, "R3 zero rate is silent", c, 0);
    endtask

    task automatic test_rate_rewrite();
        int idx;
        wr(1'b0, 16'd7);
        first_tick(7, idx);
        repeat (3) @(negedge clk);
        wr(1'b0, 16'd5);
        first_tick(5, idx);
        check(idx == 5, "R8 rewrite mid-count restarts phase", idx, 5);
    endtask

    task automatic test_div_mean();
        int c;
        wr(1'b0, 16'd10);
        count_ticks(4096, c);
        check(c >= 408 && c <= 410, "R10 divider mean over 4096 clocks", c, 409);
    endtask

    task automatic test_acc_pow2();
        int idx;
        int gaps_ok;
        int prev;
        wr(1'b1, CTL_RUN_ACC);
        wr(1'b0, 16'h4000);
        first_tick(4, idx);
        check(idx == 4, "R5 first carry after 4 clocks", idx, 4);
        gaps_ok = 1;
        prev = 0;
        for (int j = 1; j <= 40; j++) begin
            @(negedge clk);
            if (tick_o) begin
                if (j - prev != 4) gaps_ok = 0;
                prev = j;
            end
        end
        check(gaps_ok == 1 && prev == 40, "R5 carry spacing for 0x4000", prev, 40);
    endtask

    task automatic test_acc_mean();
        int c;
        wr(1'b0, 16'h1235);
        count_ticks(65536, c);
        check(c >= 16'h1234 && c <= 16'h1236, "R4 accumulator mean over 2^16 clocks", c, 16'h1235);
    endtask

    task automatic test_mode_switch();
        int idx;
        // Rate 0x8000: divider period 32768, accumulator period 2.
        wr(1'b1, CTL_RUN_DIV);
        wr(1'b0, 16'h8000);
        repeat (9) @(negedge clk);
        wr(1'b1, CTL_RUN_ACC);
        first_tick(2, idx);
        check(idx == 2, "R9 R6 switch to accumulator mode", idx, 2);
        wr(1'b0, 16'd6);
        repeat (100) @(negedge clk);
        wr(1'b1, CTL_RUN_DIV);
        first_tick(6, idx);
        check(idx == 6, "R9 R6 switch back to divider mode", idx, 6);
    endtask

    task automatic test_run_gate();
        int c;
        int idx;
        wr(1'b0, 16'd2);
        repeat (7) @(negedge clk);
        wr(1'b1, CTL_STOP);
        check(tick_o == 1'b0, "R7 low right after run cleared", int'(tick_o), 0);
        count_ticks(50, c);
        check(c == 0, "R7 no pulses while stopped", c, 0);
        wr(1'b1, CTL_RUN_DIV);
        first_tick(2, idx);
        check(idx == 2, "R7 full period after run set", idx, 2);
        wr(1'b1, CTL_RUN_ACC & ~16'h0080);
        count_ticks(50, c);
        check(c == 0, "R6 run bit 7 clear in accumulator mode", c, 0);
    endtask

    initial begin
        rst     = 1'b1;
        wr_en   = 1'b0;
        wr_sel  = 1'b0;
        wr_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_div_period();
        test_div_one();
        test_div_zero();
        test_rate_rewrite();
        test_div_mean();
        test_acc_pow2();
        test_acc_mean();
        test_mode_switch();
        test_run_gate();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_fail);
        $finish;
    end

endmodule